// File: doc/BRIEF.md
# Adaptive Steepest-Descent Calibration Weight Estimator

This block tracks three correction weights for a multi-stage subranging converter: a reference-level error, a stage gain error and an offset. Each accepted sample carries a three-entry input vector and the code the converter actually produced. The block predicts the code as the dot product of that vector with its running weights and takes the prediction minus the measured code as the error. It then moves every weight against the gradient by a step that is a power-of-two fraction of input times error.

The step fraction is held as a right-shift amount. It begins coarse. After a programmed number of completed updates it switches to a finer value. Whenever a candidate update would make any weight grow too much, the same sample is retried with the next finer step. A separate temperature-change strobe copies the running estimate into a second, active register set that downstream correction logic uses. All values are signed fixed point with 16 bits and 8 fraction bits.

Top module: `lms_cal_estimator`

## Requirements
- R1: While and directly after reset, every running and active weight is zero, the error output is zero, the step shift equals INIT_SH (2), `in_ready` is 1 and `done` is 0.
- R2: For an accepted sample, `err_out` becomes the saturated 16-bit value of round-half-up((sum of x_i*w_i) / 256) minus the measured code. The sum uses the weights held before the update. The weight for index i sits at bits [16*i+15:16*i] of the flat vectors: index 0 is the reference error, 1 the stage gain error, 2 the offset.
- R3: Each candidate weight is w_i minus round-half-up(x_i*err / 2^(8+s)) for step shift s, saturated to the signed 16-bit range.
- R4: A weight "grows" when |candidate| > |w_i| + GROW_LIM. If any weight grows and s < MAX_SH, then s increases by one and the same sample is recomputed. The shift never decreases.
- R5: At s = MAX_SH, a weight that would grow keeps its old value, and the remaining weights take their candidates.
- R6: The step shift starts at INIT_SH. When the completed-update count reaches PHASE_ITERS, the shift becomes LATE_SH (6) if it is smaller than that.
- R7: A one-cycle `temp_evt` copies the running weights into `act_w` at the next edge. Without it, `act_w` does not change.
- R8: A sample is taken only when `in_valid` and `in_ready` are both 1. Inputs presented while `in_ready` is 0 are ignored.
- R9: `done` pulses high for one cycle after the update that makes the completed count equal to `iter_target`.
- R10: The step shift never exceeds MAX_SH (10).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Sample offered |
| in_ready | output | 1 | Block idle and able to take a sample |
| in_x | input | 48 | Input vector, three signed Q8.8 entries |
| in_meas | input | 16 | Measured output code, signed Q8.8 |
| iter_target | input | 16 | Completed-update count that raises `done` |
| temp_evt | input | 1 | Temperature-change strobe, commits the estimate |
| est_w | output | 48 | Running weight estimate |
| act_w | output | 48 | Committed (active) coefficients |
| err_out | output | 16 | Error of the latest accepted sample |
| step_shift | output | 4 | Current step-size shift |
| done | output | 1 | One-cycle pulse when the target count is reached |

## Verification
The bench builds the block with PHASE_ITERS set to 24 and the other parameters at their defaults (INIT_SH 2, LATE_SH 6, MAX_SH 10, GROW_LIM 256), and drives `iter_target` at 30. With these values the switch to the fine step and the `done` pulse both happen within the first few dozen samples. Random samples of small amplitude cover the coarse and fine phases. Directed vectors near full scale saturate the error and push the retry loop to its shift ceiling, where both frozen and updated weights can be seen at once.

// File: rtl/lms_cal_pkg.sv
package lms_cal_pkg;
    localparam int DW   = 16;   // fixed-point word
    localparam int FW   = 8;    // fraction bits
    localparam int WIDE = 48;   // internal accumulator width

    typedef logic signed [DW-1:0]   fx_t;
    typedef logic signed [WIDE-1:0] wide_t;

    typedef enum logic [1:0] {ST_IDLE, ST_ERR, ST_UPD} est_state_e;

    typedef struct packed {
        fx_t  w_new;
        logic grows;
    } wt_cand_t;

    function automatic fx_t sat_fx(input wide_t v);
        wide_t hi;
        wide_t lo;
        hi = wide_t'((64'sd1 <<< (DW - 1)) - 64'sd1);
        lo = -hi - wide_t'(1);
        if (v > hi)      return fx_t'(hi);
        else if (v < lo) return fx_t'(lo);
        else             return v[DW-1:0];
    endfunction

    function automatic wide_t abs_w(input wide_t v);
        return (v < 0) ? -v : v;
    endfunction
endpackage

// File: rtl/lms_err_calc.sv
module lms_err_calc
    import lms_cal_pkg::*;
#(
    parameter int NW = 3
) (
    input  logic [NW*DW-1:0] x_flat,
    input  logic [NW*DW-1:0] w_flat,
    input  fx_t              meas,
    output fx_t              err
);
    wide_t acc;

    always_comb begin
        acc = -(wide_t'(meas) <<< FW);
        for (int i = 0; i < NW; i++) begin
            acc = acc + wide_t'(fx_t'(x_flat[i*DW +: DW])) * wide_t'(fx_t'(w_flat[i*DW +: DW]));
        end
        err = sat_fx((acc + (wide_t'(1) <<< (FW - 1))) >>> FW);
    end
endmodule

// File: rtl/lms_wt_step.sv
module lms_wt_step
    import lms_cal_pkg::*;
#(
    parameter int SHW      = 4,
    parameter int GROW_LIM = 256
) (
    input  fx_t            x_i,
    input  fx_t            w_i,
    input  fx_t            err,
    input  logic [SHW-1:0] sh,
    output wt_cand_t       cand
);
    wide_t prod;
    wide_t rnd;
    wide_t dlt;
    wide_t raw;

    always_comb begin
        prod       = wide_t'(x_i) * wide_t'(err);
        rnd        = wide_t'(1) <<< (FW + int'(sh) - 1);
        dlt        = (prod + rnd) >>> (FW + int'(sh));
        raw        = wide_t'(w_i) - dlt;
        cand.w_new = sat_fx(raw);
        cand.grows = abs_w(wide_t'(cand.w_new)) > (abs_w(wide_t'(w_i)) + wide_t'(GROW_LIM));
    end
endmodule

// File: rtl/lms_cal_estimator.sv
module lms_cal_estimator
    import lms_cal_pkg::*;
#(
    parameter int NW          = 3,
    parameter int INIT_SH     = 2,
    parameter int LATE_SH     = 6,
    parameter int MAX_SH      = 10,
    parameter int PHASE_ITERS = 1000,
    parameter int GROW_LIM    = 256,
    parameter int ITW         = 16,
    localparam int SHW        = $clog2(MAX_SH + 1),
    localparam int VW         = NW * DW
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           in_valid,
    output logic           in_ready,
    input  logic [VW-1:0]  in_x,
    input  logic [DW-1:0]  in_meas,
    input  logic [ITW-1:0] iter_target,
    input  logic           temp_evt,
    output logic [VW-1:0]  est_w,
    output logic [VW-1:0]  act_w,
    output logic [DW-1:0]  err_out,
    output logic [SHW-1:0] step_shift,
    output logic           done
);
    est_state_e     st;
    logic [VW-1:0]  x_lat;
    fx_t            m_lat;
    logic [VW-1:0]  w_est;
    logic [VW-1:0]  w_act;
    fx_t            err_q;
    fx_t            err_c;
    logic [SHW-1:0] sh;
    logic [ITW-1:0] iter;
    logic [ITW-1:0] iter_nx;
    logic           done_q;
    wt_cand_t       cand [NW];
    logic [NW-1:0]  grow;
    logic           any_grow;

    lms_err_calc #(.NW(NW)) u_err (
        .x_flat (x_lat),
        .w_flat (w_est),
        .meas   (m_lat),
        .err    (err_c)
    );

    for (genvar g = 0; g < NW; g++) begin : g_wt
        lms_wt_step #(.SHW(SHW), .GROW_LIM(GROW_LIM)) u_step (
            .x_i  (fx_t'(x_lat[g*DW +: DW])),
            .w_i  (fx_t'(w_est[g*DW +: DW])),
            .err  (err_q),
            .sh   (sh),
            .cand (cand[g])
        );
        assign grow[g] = cand[g].grows;
    end

    assign any_grow = |grow;
    assign iter_nx  = (&iter) ? iter : iter + ITW'(1);

    always_ff @(posedge clk) begin
        if (rst) begin
            st     <= ST_IDLE;
            x_lat  <= '0;
            m_lat  <= '0;
            w_est  <= '0;
            w_act  <= '0;
            err_q  <= '0;
            sh     <= SHW'(INIT_SH);
            iter   <= '0;
            done_q <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (temp_evt) w_act <= w_est;
            case (st)
                ST_IDLE: begin
                    if (in_valid) begin
                        x_lat <= in_x;
                        m_lat <= fx_t'(in_meas);
                        st    <= ST_ERR;
                    end
                end
                ST_ERR: begin
                    err_q <= err_c;
                    st    <= ST_UPD;
                end
                ST_UPD: begin
                    if (any_grow && (sh < SHW'(MAX_SH))) begin
                        sh <= sh + SHW'(1);
                    end else begin
                        for (int i = 0; i < NW; i++) begin
                            if (!grow[i]) w_est[i*DW +: DW] <= cand[i].w_new;
                        end
                        iter   <= iter_nx;
                        done_q <= (iter_nx == iter_target);
                        if ((iter_nx == ITW'(PHASE_ITERS)) && (sh < SHW'(LATE_SH)))
                            sh <= SHW'(LATE_SH);
                        st <= ST_IDLE;
                    end
                end
                default: st <= ST_IDLE;
            endcase
        end
    end

    assign in_ready   = (st == ST_IDLE);
    assign est_w      = w_est;
    assign act_w      = w_act;
    assign err_out    = err_q;
    assign step_shift = sh;
    assign done       = done_q;

    // R10: shift ceiling
    p_shift_cap_r10: assert property (@(posedge clk) disable iff (rst) sh <= SHW'(MAX_SH));
    // R4: the shift only moves toward finer steps
    p_shift_mono_r4: assert property (@(posedge clk) disable iff (rst) 1'b1 |=> (sh >= $past(sh)));
    // R7: active set moves only on the temperature strobe
    p_act_hold_r7: assert property (@(posedge clk) disable iff (rst) !temp_evt |=> $stable(w_act));
    // R8: latched sample is frozen while busy
    p_busy_hold_r8: assert property (@(posedge clk) disable iff (rst)
        (st != ST_IDLE) |=> ($stable(x_lat) && $stable(m_lat)));
    // R3: estimate is written only by the update step
    p_est_write_r3: assert property (@(posedge clk) disable iff (rst)
        (st != ST_UPD) |=> $stable(w_est));
    // R9: done is a single-cycle pulse
    p_done_pulse_r9: assert property (@(posedge clk) disable iff (rst) done_q |=> !done_q);
endmodule

// File: tb/tb_lms_cal_estimator.sv
module tb_lms_cal_estimator;
    localparam int PHASE   = 24;
    localparam int MAXS    = 10;
    localparam int LATES   = 6;
    localparam int GLIM    = 256;
    localparam int TARGET  = 30;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [47:0] in_x = '0;
    logic [15:0] in_meas = '0;
    logic [15:0] iter_target = 16'(TARGET);
    logic        temp_evt = 1'b0;
    logic [47:0] est_w;
    logic [47:0] act_w;
    logic [15:0] err_out;
    logic [3:0]  step_shift;
    logic        done;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    longint mw [3];
    longint ms;
    longint me;
    longint miter;

    lms_cal_estimator #(.PHASE_ITERS(PHASE)) dut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
        .in_x(in_x), .in_meas(in_meas), .iter_target(iter_target),
        .temp_evt(temp_evt), .est_w(est_w), .act_w(act_w), .err_out(err_out),
        .step_shift(step_shift), .done(done)
    );

    always #2 clk = ~clk;

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic longint sat16(input longint v);
        if (v > 32767) return 32767;
        if (v < -32768) return -32768;
        return v;
    endfunction

    function automatic longint labs(input longint v);
        return (v < 0) ? -v : v;
    endfunction

    function automatic longint wget(input logic [47:0] f, input int i);
        return longint'($signed(f[i*16 +: 16]));
    endfunction

    function automatic longint rnd(input int lim);
        return longint'($urandom_range(2 * lim)) - longint'(lim);
    endfunction

    task automatic model_step(input longint x [3], input longint m);
        longint acc, c [3], p;
        bit g [3];
        bit any;
        acc = -(m * 256);
        for (int i = 0; i < 3; i++) acc += x[i] * mw[i];
        me = sat16((acc + 128) >>> 8);
        forever begin
            any = 0;
            for (int i = 0; i < 3; i++) begin
                p = x[i] * me;
                c[i] = sat16(mw[i] - ((p + (64'sd1 <<< (8 + ms - 1))) >>> (8 + ms)));
                g[i] = labs(c[i]) > labs(mw[i]) + GLIM;
                any |= g[i];
            end
            if (any && ms < MAXS) ms++;
            else break;
        end
        for (int i = 0; i < 3; i++) if (!g[i]) mw[i] = c[i];
        miter++;
        if (miter == PHASE && ms < LATES) ms = LATES;
    endtask

    task automatic send(input longint x0, x1, x2, m, input bit linger, input string req);
        longint xv [3];
        xv[0] = x0; xv[1] = x1; xv[2] = x2;
        @(negedge clk);
        in_valid = 1'b1;
        in_x     = {16'(x2), 16'(x1), 16'(x0)};
        in_meas  = 16'(m);
        @(negedge clk);
        if (linger) begin
            in_x    = ~in_x;
            in_meas = ~in_meas;
            @(negedge clk);
        end
        in_valid = 1'b0;
        while (!in_ready) @(negedge clk);
        model_step(xv, m);
        for (int i = 0; i < 3; i++)
            chk(wget(est_w, i) == mw[i], req, wget(est_w, i), mw[i]);
        chk(longint'($signed(err_out)) == me, "R2 error", longint'($signed(err_out)), me);
        chk(longint'(step_shift) == ms, "R4/R6 shift", longint'(step_shift), ms);
        chk(done == (miter == TARGET), "R9 done", longint'(done), longint'(miter == TARGET));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=0 expected=1");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        longint snap [3];
        void'($urandom(32'd1234));
        for (int i = 0; i < 3; i++) mw[i] = 0;
        ms = 2; me = 0; miter = 0;
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        for (int i = 0; i < 3; i++) begin
            chk(wget(est_w, i) == 0, "R1 est", wget(est_w, i), 0);
            chk(wget(act_w, i) == 0, "R1 act", wget(act_w, i), 0);
        end
        chk(step_shift == 4'd2, "R1 shift", longint'(step_shift), 2);
        chk(in_ready == 1'b1, "R1 ready", longint'(in_ready), 1);
        chk(done == 1'b0, "R1 done", longint'(done), 0);
        chk(err_out == 16'd0, "R1 err", longint'(err_out), 0);

        // R3 coarse phase, small random samples
        for (int k = 0; k < PHASE; k++)
            send(rnd(256), rnd(256), rnd(256), rnd(512), 0, "R3 coarse update");
        // R6 schedule switch
        chk(step_shift == 4'(LATES), "R6 fine step after phase", longint'(step_shift), LATES);

        for (int k = 0; k < 8; k++)
            send(rnd(256), rnd(256), rnd(256), rnd(512), 0, "R3 fine update");

        // R7 commit on temperature strobe
        @(negedge clk);
        temp_evt = 1'b1;
        @(negedge clk);
        temp_evt = 1'b0;
        for (int i = 0; i < 3; i++) begin
            snap[i] = mw[i];
            chk(wget(act_w, i) == mw[i], "R7 commit", wget(act_w, i), mw[i]);
        end
        send(rnd(256), rnd(256), rnd(256), rnd(512), 0, "R3 update after commit");
        for (int i = 0; i < 3; i++)
            chk(wget(act_w, i) == snap[i], "R7 active held", wget(act_w, i), snap[i]);

        // R8 inputs while busy ignored
        send(rnd(256), rnd(256), rnd(256), rnd(512), 1, "R8 busy inputs ignored");
        send(rnd(256), rnd(256), rnd(256), rnd(512), 1, "R8 busy inputs ignored");

        // R4/R5 saturating vector drives the shift to its ceiling
        send(32767, 32767, 32767, -32768, 0, "R5 frozen at ceiling");
        chk(step_shift == 4'(MAXS), "R4 shift at ceiling", longint'(step_shift), MAXS);
        send(-32768, 32767, -32768, 32767, 0, "R5 frozen at ceiling");
        // mixed: index 1 small so it updates while others freeze
        send(32767, 64, 32767, -32768, 0, "R5 mixed freeze");
        send(-32768, -32768, 256, 32767, 0, "R5 mixed freeze");

        // R3 random mix at fine step
        for (int k = 0; k < 12; k++)
            send(rnd(4096), rnd(4096), rnd(4096), rnd(8192), 0, "R3 random update");
        chk(step_shift <= 4'(MAXS), "R10 shift bound", longint'(step_shift), MAXS);

        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule